// File: doc/BRIEF.md
# Prescaled One-Shot Countdown Timer

This block is a 32-bit one-shot countdown timer for use inside a local interrupt controller. A free-running base stage produces a boundary every 16 clocks. A second stage divides those boundaries by a power of two, chosen through a 4-bit divide-configuration register. Software writes an initial count. The timer aligns to the next base boundary, then takes one count off for every 16 × divisor clocks. When the count reaches zero it raises a one-cycle expiry pulse.

Three write strobes share one 32-bit data bus: initial count, divide configuration and current count. The current-count strobe is accepted and has no effect. The remaining count and the stored configuration can be read back on output ports at any time. Reload, vector-table handling and address decoding belong to the surrounding controller and are not part of this block.

Top module: `tick_countdown`

## Requirements
- R1: The divisor is 2^((code + 1) mod 8), where the 3-bit code is {cfg[3], cfg[1:0]}. Code 000 divides by 2, code 110 by 128 and code 111 by 1.
- R2: A divide-configuration write stores only data bits 3, 1 and 0 (mask 0xB). On `div_cfg`, all other bits read zero. The stored value appears on the clock after the write edge.
- R3: While running, `cur_count` drops by exactly one every 16 × divisor clocks and never changes by more than one on an edge.
- R4: An initial-count write loads the full 32-bit `wdata` into `cur_count` on the write edge and restarts the countdown, whatever state the timer was in.
- R5: Base boundaries fall on edges k = 16, 32, 48, … counted from the first edge after reset release. After a load on edge L, counting aligns at the first boundary B0 > L, and expiry falls on edge B0 + 16 × divisor × count.
- R6: A current-count write leaves `cur_count` unchanged.
- R7: `expire` is high for exactly one cycle, which starts at the edge where `cur_count` becomes zero. `cur_count` then stays at zero until the next initial-count write.
- R8: Loading zero stops the timer, and no expiry pulse follows.
- R9: A new divide configuration written during a run takes effect only after the division period in progress has completed under the old divisor.
- R10: After reset, `cur_count`, `div_cfg` and `expire` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wdata | input | 32 | Shared write data |
| wr_init | input | 1 | Initial-count write strobe |
| wr_div | input | 1 | Divide-configuration write strobe |
| wr_cur | input | 1 | Current-count write strobe (has no effect) |
| cur_count | output | 32 | Remaining count, in units of 16 × divisor clocks |
| div_cfg | output | 32 | Stored divide configuration (bits 3, 1, 0) |
| expire | output | 1 | One-cycle expiry pulse |

## Verification
A load or configuration write shows on `cur_count` or `div_cfg` after the write edge itself. Each decrement lands on an edge B0 + 16 × divisor × j, and `expire` is high for the single cycle after edge B0 + 16 × divisor × count. The bench keeps its own edge counter, which restarts at reset exactly as the base stage does. It derives B0 and the expiry edge from the load edge and the divisor, and samples every output on the falling edge after the edge on which the result is due. For the divisor-change case, the bench computes the expiry edge that only a deferred switch produces; an immediate switch would expire 16 clocks earlier.

// File: rtl/tick_countdown_pkg.sv
package tick_countdown_pkg;

  localparam int CODE_W = 3;
  localparam int DIV_W  = 8;

  // Gather the non-contiguous configuration bits into one code.
  function automatic logic [CODE_W-1:0] cfg_to_code(input logic [3:0] raw);
    return {raw[3], raw[1:0]};
  endfunction

  // Shift amount wraps modulo 8, so code 7 selects a divisor of one.
  function automatic logic [CODE_W-1:0] code_to_shift(input logic [CODE_W-1:0] code);
    return code + CODE_W'(1);
  endfunction

  function automatic logic [DIV_W-1:0] shift_to_div(input logic [CODE_W-1:0] sh);
    return DIV_W'(1) << sh;
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_countdown_pkg::*;
#(
  parameter int BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [CODE_W-1:0] code_req,
  output logic              dec_o
);

  logic              base_tick;
  logic              armed;
  logic [DIV_W-1:0]  div_cnt;
  logic [CODE_W-1:0] act_shift;
  logic              div_wrap;

  generate
    if (BASE_LOG2 > 0) begin : g_base
      logic [BASE_LOG2-1:0] base_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) base_cnt <= '0;
        else        base_cnt <= base_cnt + 1'b1;
      end
      assign base_tick = (base_cnt == '1);
    end else begin : g_nobase
      assign base_tick = 1'b1;
    end
  endgenerate

  assign div_wrap = (div_cnt == shift_to_div(act_shift) - DIV_W'(1));
  assign dec_o    = run && !restart && armed && base_tick && div_wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      div_cnt   <= '0;
      act_shift <= code_to_shift('0);
    end else if (restart || !run) begin
      armed     <= 1'b0;
      div_cnt   <= '0;
      act_shift <= code_to_shift(code_req);
    end else if (base_tick) begin
      if (!armed) begin
        armed     <= 1'b1;
        div_cnt   <= '0;
        act_shift <= code_to_shift(code_req);
      end else if (div_wrap) begin
        div_cnt   <= '0;
        act_shift <= code_to_shift(code_req);
      end else begin
        div_cnt   <= div_cnt + 1'b1;
      end
    end
  end

  // The edge straight after a load is never a decrement: alignment comes first.
  assert_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !dec_o);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o  <= '0;
      expire_o <= 1'b0;
    end else if (load) begin
      count_o  <= load_val;
      expire_o <= 1'b0;
    end else if (dec) begin
      count_o  <= count_o - 1'b1;
      expire_o <= (count_o == CNT_W'(1));
    end else begin
      expire_o <= 1'b0;
    end
  end

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_o == $past(load_val));
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count_o != '0) |=> (count_o == $past(count_o) || count_o == $past(count_o) - 1'b1));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
  assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> count_o == '0);
  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == '0 && !load) |=> (count_o == '0 && !expire_o));
  assert_zero_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val == '0) |=> !expire_o);

endmodule

// File: rtl/tick_countdown.sv
module tick_countdown
  import tick_countdown_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] wdata,
  input  logic             wr_init,
  input  logic             wr_div,
  input  logic             wr_cur,
  output logic [CNT_W-1:0] cur_count,
  output logic [CNT_W-1:0] div_cfg,
  output logic             expire
);

  logic [CODE_W-1:0] cfg_code;
  logic              dec;
  logic              running;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_code <= '0;
    else if (wr_div) cfg_code <= cfg_to_code(wdata[3:0]);
  end

  always_comb begin
    div_cfg    = '0;
    div_cfg[3] = cfg_code[2];
    div_cfg[1] = cfg_code[1];
    div_cfg[0] = cfg_code[0];
  end

  assign running = (cur_count != '0);

  tick_prescaler #(.BASE_LOG2(BASE_LOG2)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (wr_init),
    .run      (running),
    .code_req (cfg_code),
    .dec_o    (dec)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_init),
    .load_val (wdata),
    .dec      (dec),
    .count_o  (cur_count),
    .expire_o (expire)
  );

  assert_cfg_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> div_cfg == ($past(wdata) & CNT_W'(32'hB)));
  assert_ro_current_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cur && !wr_init && !dec) |=> cur_count == $past(cur_count));

endmodule

// File: tb/tick_countdown_test.sv
`timescale 1ns/1ps
module tick_countdown_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic        wr_init = 1'b0, wr_div = 1'b0, wr_cur = 1'b0;
  logic [31:0] cur_count, div_cfg;
  logic        expire;

  int cyc = 0;
  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  tick_countdown uut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .wr_init(wr_init),
    .wr_div(wr_div), .wr_cur(wr_cur), .cur_count(cur_count),
    .div_cfg(div_cfg), .expire(expire)
  );

  // {configuration word, initial count}
  localparam logic [63:0] VECS [0:8] = '{
    {32'h0000_0000, 32'd3}, {32'h0000_000B, 32'd5}, {32'h0000_0001, 32'd2},
    {32'h0000_0002, 32'd1}, {32'h0000_0003, 32'd2}, {32'h0000_0008, 32'd1},
    {32'h0000_0009, 32'd1}, {32'h0000_000A, 32'd1}, {32'hFFFF_FFF4, 32'd2}
  };

  function automatic int divisor_of(input logic [31:0] v);
    int code;
    code = (v[3] ? 4 : 0) + (v[1] ? 2 : 0) + (v[0] ? 1 : 0);
    if (code == 7) return 1;
    return 2 << code;
  endfunction

  function automatic int first_boundary(input int l);
    return ((l / 16) + 1) * 16;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_div(input logic [31:0] v);
    wdata = v; wr_div = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_div = 1'b0;
  endtask

  task automatic load_count(input logic [31:0] v, output int l);
    wdata = v; wr_init = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_init = 1'b0;
    l = cyc;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_expiry(input int limit, output int at);
    at = -1;
    for (int k = 0; k < limit; k++) begin
      if (expire) begin at = cyc; return; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int l, b0, e, at, dv, cnt, pulses;
    logic [31:0] cfgw;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(cur_count == 0, "R10", "count in reset", cur_count, 0);
    check(div_cfg == 0, "R10", "cfg in reset", div_cfg, 0);
    check(expire == 0, "R10", "expire in reset", expire, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      cfgw = VECS[i][63:32];
      cnt  = int'(VECS[i][31:0]);
      dv   = divisor_of(cfgw);
      write_div(cfgw);
      check(div_cfg == (cfgw & 32'hB), "R2", "cfg readback", div_cfg, cfgw & 32'hB);
      load_count(cnt, l);
      check(cur_count == cnt, "R4", "count after load", cur_count, cnt);
      b0 = first_boundary(l);
      e  = b0 + 16 * dv * cnt;
      wait_cyc(b0 + 16 * dv - 1);
      check(cur_count == cnt, "R3", "count before first decrement", cur_count, cnt);
      if (cnt > 1) begin
        @(negedge clk);
        check(cur_count == cnt - 1, "R3", "count after first decrement", cur_count, cnt - 1);
      end
      wait_expiry(5000, at);
      check(at == e, "R1_R5", "expiry edge", at, e);
      check(cur_count == 0, "R7", "count at expiry", cur_count, 0);
      @(negedge clk);
      check(expire == 0, "R7", "pulse width", expire, 0);
    end

    // R6: current-count write ignored
    write_div(32'hB);
    load_count(8, l);
    wdata = 32'h55; wr_cur = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_cur = 1'b0;
    check(cur_count == 8, "R6", "count after current write", cur_count, 8);

    // R4: reload in mid-run restarts
    repeat (40) @(negedge clk);
    load_count(2, l);
    check(cur_count == 2, "R4", "count after reload", cur_count, 2);
    e = first_boundary(l) + 32;
    wait_expiry(5000, at);
    check(at == e, "R4", "expiry after reload", at, e);

    // R7: hold at zero with no further pulse
    @(negedge clk);
    pulses = 0;
    for (int k = 0; k < 60; k++) begin
      if (expire) pulses++;
      @(negedge clk);
    end
    check(pulses == 0 && cur_count == 0, "R7", "zero hold pulses", pulses, 0);

    // R8: zero load stops without a pulse
    load_count(3, l);
    repeat (5) @(negedge clk);
    load_count(0, l);
    check(cur_count == 0, "R8", "count after zero load", cur_count, 0);
    pulses = 0;
    for (int k = 0; k < 200; k++) begin
      if (expire) pulses++;
      @(negedge clk);
    end
    check(pulses == 0, "R8", "pulses after zero load", pulses, 0);

    // R9: divisor change waits for the period in progress
    write_div(32'h0);
    load_count(3, l);
    b0 = first_boundary(l);
    wait_cyc(b0 + 32);
    check(cur_count == 2, "R9", "count before divisor change", cur_count, 2);
    write_div(32'hB);
    e = b0 + 80;
    wait_expiry(5000, at);
    check(at == e, "R9", "expiry after divisor change", at, e);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule